// File: doc/BRIEF.md
# Annunciator Tone Source Selector

This block drives one buzzer pin from one of three tone sources. In software mode the pin follows a toggle bit that firmware writes, so any pulse width or duty pattern that firmware produces comes out unchanged, one register stage later. In timer mode a toggle flip-flop flips on every underflow pulse of a general-purpose timer. In fixed mode a divider, advanced by a one-cycle reference tick, produces a low-frequency tone that is nominally 500 Hz.

When the chip runs from an external 13 MHz clock, the reference tick is faster and the fixed tone would come out near 528 Hz. The divider therefore has two terminal counts. The shorter count, for the uncorrected external-clock case, is used only when the external-clock flag is set and the override bit is clear. When the digital audio interface is enabled, the pin carries that interface's master clock instead of any tone, so the buzzer is usable only while the interface is off. Both hardware toggle flip-flops keep running while they are not selected.

Top module: `annunciator_tone_sel`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `buz_pin` is 0 when `audio_en` is 0. Both hardware toggle flip-flops reset to 0.
- R2: With `hw_mode`=0, `buz_pin` equals the value `sw_tone` had at the previous rising clock edge, for any pulse width, including single-cycle pulses.
- R3: The underflow flip-flop inverts on every clock edge at which `uf_pulse`=1, including pulses on consecutive cycles, and holds otherwise.
- R4: With `hw_mode`=1 and `fixed_sel`=0, `buz_pin` follows the underflow flip-flop with one register stage of delay.
- R5: With `hw_mode`=1 and `fixed_sel`=1, `buz_pin` follows the fixed-tone flip-flop. That flip-flop inverts once every `HALF_STD` reference ticks when the shorter count is not selected.
- R6: With `ext_clk`=1 and `ext_ovr`=0, the fixed-tone flip-flop inverts once every `HALF_EXT` reference ticks.
- R7: With `ext_ovr`=1, the count is `HALF_STD` whatever the value of `ext_clk`.
- R8: Edges on which `ref_tick`=0 leave the divider and the fixed-tone flip-flop unchanged.
- R9: `audio_en`=1 makes `buz_pin` equal to `audio_mclk` in the same cycle, ahead of every tone source.
- R10: A change of source takes effect at the next clock edge. Flip-flops that are not selected keep counting and toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_tone | input | 1 | Toggle bit written by software |
| hw_mode | input | 1 | 0: software source, 1: hardware source |
| fixed_sel | input | 1 | Hardware source pick. 0: timer underflow, 1: fixed tone |
| ext_clk | input | 1 | Chip is running from the external 13 MHz clock |
| ext_ovr | input | 1 | Forces the standard count while `ext_clk` is set |
| uf_pulse | input | 1 | One-cycle timer underflow pulse |
| ref_tick | input | 1 | One-cycle reference tick enable for the divider |
| audio_en | input | 1 | Audio interface owns the pin |
| audio_mclk | input | 1 | Audio interface master clock |
| buz_pin | output | 1 | Buzzer pin |

## Verification
An underflow pulse, a reference tick and a change of source can all land on the same clock edge. The bench applies all three at once and relies on R10: the newly selected flip-flop must show its value from before that edge, and the flip-flop that was just deselected must still toggle. Enabling the audio interface while the hidden flip-flops are still toggling checks that R9 takes priority. Once the interface is released, the pin must show the tone state that built up while the pin was owned. Counting pin edges over a fixed number of ticks confirms which terminal count is in use.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_UF  = 2'd1,
    SRC_FIX = 2'd2
  } tone_src_e;

  function automatic tone_src_e pick_src(input logic hw, input logic fsel);
    if (!hw)      return SRC_SW;
    else if (fsel) return SRC_FIX;
    else          return SRC_UF;
  endfunction
endpackage

// File: rtl/uf_toggle.sv
module uf_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (pulse) q <= ~q;
  end
endmodule

// File: rtl/fixed_tone_div.sv
module fixed_tone_div #(
  parameter int HALF_STD = 16,
  parameter int HALF_EXT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic short_cnt,
  output logic q
);
  localparam int MAXH = (HALF_STD > HALF_EXT) ? HALF_STD : HALF_EXT;
  localparam int CW   = (MAXH < 2) ? 1 : $clog2(MAXH);
  localparam logic [CW-1:0] LAST_STD = CW'(HALF_STD - 1);
  localparam logic [CW-1:0] LAST_EXT = CW'(HALF_EXT - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = short_cnt ? LAST_EXT : LAST_STD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt <= '0;
        q   <= ~q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tone_src_mux.sv
module tone_src_mux
  import tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tone_src_e src,
  input  logic      sw_in,
  input  logic      uf_in,
  input  logic      fix_in,
  output logic      q
);
  logic nxt;

  always_comb begin
    unique case (src)
      SRC_UF:  nxt = uf_in;
      SRC_FIX: nxt = fix_in;
      default: nxt = sw_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/annunciator_tone_sel.sv
module annunciator_tone_sel
  import tone_pkg::*;
#(
  parameter int HALF_STD = 16,
  parameter int HALF_EXT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_tone,
  input  logic hw_mode,
  input  logic fixed_sel,
  input  logic ext_clk,
  input  logic ext_ovr,
  input  logic uf_pulse,
  input  logic ref_tick,
  input  logic audio_en,
  input  logic audio_mclk,
  output logic buz_pin
);
  logic      uf_q;
  logic      fix_q;
  logic      tone_q;
  tone_src_e src;

  assign src = pick_src(hw_mode, fixed_sel);

  uf_toggle u_uf (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (uf_pulse),
    .q     (uf_q)
  );

  fixed_tone_div #(
    .HALF_STD (HALF_STD),
    .HALF_EXT (HALF_EXT)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (ref_tick),
    .short_cnt (ext_clk & ~ext_ovr),
    .q         (fix_q)
  );

  tone_src_mux u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src),
    .sw_in  (sw_tone),
    .uf_in  (uf_q),
    .fix_in (fix_q),
    .q      (tone_q)
  );

  // Master clock passes straight through; it is never retimed.
  assign buz_pin = audio_en ? audio_mclk : tone_q;
endmodule

// File: rtl/tone_sel_chk.sv
module tone_sel_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_tone,
  input logic hw_mode,
  input logic fixed_sel,
  input logic uf_pulse,
  input logic ref_tick,
  input logic uf_q,
  input logic fix_q,
  input logic tone_q
);
  // R2
  sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_mode |=> tone_q == $past(sw_tone));

  // R3
  uf_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse |=> uf_q != $past(uf_q));

  // R3
  uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_pulse |=> $stable(uf_q));

  // R4
  uf_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && !fixed_sel) |=> tone_q == $past(uf_q));

  // R5
  fix_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && fixed_sel) |=> tone_q == $past(fix_q));

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(fix_q));
endmodule

bind annunciator_tone_sel tone_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_tone   (sw_tone),
  .hw_mode   (hw_mode),
  .fixed_sel (fixed_sel),
  .uf_pulse  (uf_pulse),
  .ref_tick  (ref_tick),
  .uf_q      (uf_q),
  .fix_q     (fix_q),
  .tone_q    (tone_q)
);

// File: tb/test_annunciator_tone_sel.sv
module test_annunciator_tone_sel;
  localparam int PER  = 10;
  localparam int HSTD = 6;
  localparam int HEXT = 5;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tone = 0, hw_mode = 0, fixed_sel = 0, ext_clk = 0, ext_ovr = 0;
  logic uf_pulse = 0, ref_tick = 0, audio_en = 0, audio_mclk = 0;
  logic buz_pin;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  logic prev_pin = 1'b0;
  item_t q[$];

  // independent reference state
  logic m_uf = 0, m_fix = 0, m_tone = 0;
  int   m_cnt = 0;

  always #(PER/2) clk = ~clk;

  annunciator_tone_sel #(.HALF_STD(HSTD), .HALF_EXT(HEXT)) i_annunciator_tone_sel (
    .clk(clk), .rst_n(rst_n), .sw_tone(sw_tone), .hw_mode(hw_mode),
    .fixed_sel(fixed_sel), .ext_clk(ext_clk), .ext_ovr(ext_ovr),
    .uf_pulse(uf_pulse), .ref_tick(ref_tick), .audio_en(audio_en),
    .audio_mclk(audio_mclk), .buz_pin(buz_pin)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: buz_pin=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: model the edge the current inputs will meet, push the result
  task automatic step(input string req);
    item_t it;
    int    lim;
    logic  t_n;
    lim = (ext_clk && !ext_ovr) ? HEXT : HSTD;
    t_n = !hw_mode ? sw_tone : (fixed_sel ? m_fix : m_uf);
    if (uf_pulse) m_uf = ~m_uf;
    if (ref_tick) begin
      if (m_cnt >= lim - 1) begin m_cnt = 0; m_fix = ~m_fix; end
      else m_cnt++;
    end
    m_tone = t_n;
    it.exp = audio_en ? audio_mclk : t_n;
    it.req = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pop one expected item per edge, sample a quarter period later
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(PER/4);
      if (q.size() > 0) begin
        it = q.pop_front();
        check(buz_pin, it.exp, it.req);
        if (buz_pin !== prev_pin) edges++;
        prev_pin = buz_pin;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    {sw_tone, hw_mode, fixed_sel, ext_clk, ext_ovr, uf_pulse, ref_tick, audio_en, audio_mclk} = '0;
    repeat (3) @(negedge clk);
    check(buz_pin, 1'b0, "R1 in reset");
    m_uf = 0; m_fix = 0; m_tone = 0; m_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
    check(buz_pin, 1'b0, "R1 after reset");
    prev_pin = 1'b0;
  endtask

  task automatic tone_window(input logic ext, input logic ovr, input int exp_edges, input string req);
    do_reset();
    hw_mode = 1; fixed_sel = 1; ext_clk = ext; ext_ovr = ovr;
    edges = 0;
    ref_tick = 1;
    repeat (60) step(req);
    ref_tick = 0;
    repeat (2) step(req);
    n_chk++;
    if (edges != exp_edges) begin
      n_bad++;
      $display("FAIL %s: edges=%0d expected %0d", req, edges, exp_edges);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", wd, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: software path, assorted pulse widths
    for (int i = 0; i < 24; i++) begin
      sw_tone = (i % 5 == 0) || (i % 7 < 3);
      step("R2 software");
    end
    sw_tone = 1; step("R2 single pulse"); sw_tone = 0; step("R2 single pulse");

    // R3/R4: underflow source, back-to-back and spaced pulses
    hw_mode = 1; fixed_sel = 0;
    for (int i = 0; i < 20; i++) begin
      uf_pulse = (i < 4) || (i % 3 == 0);
      step("R3 R4 underflow");
    end
    uf_pulse = 0; repeat (2) step("R4 underflow idle");

    // R8: no ticks, fixed flip-flop must hold
    fixed_sel = 1;
    repeat (8) step("R8 no tick");

    // R10: switch source together with a pulse and a tick on one edge
    fixed_sel = 0; uf_pulse = 1; ref_tick = 1; step("R10 switch");
    fixed_sel = 1; uf_pulse = 1; ref_tick = 1; step("R10 switch");
    uf_pulse = 0;
    repeat (HSTD * 2) step("R10 hidden running");
    ref_tick = 0;
    hw_mode = 0; sw_tone = 1; step("R10 to software");

    // R9: audio interface takes the pin while sources keep moving
    audio_en = 1; hw_mode = 1; fixed_sel = 0;
    for (int i = 0; i < 12; i++) begin
      audio_mclk = i[0];
      uf_pulse = i[1];
      ref_tick = 1;
      step("R9 audio priority");
    end
    audio_en = 0; uf_pulse = 0; ref_tick = 0;
    repeat (2) step("R9 release");

    // R5/R6/R7: count pin edges over 60 ticks
    tone_window(1'b0, 1'b0, 60 / HSTD, "R5 standard count");
    tone_window(1'b1, 1'b0, 60 / HEXT, "R6 external count");
    tone_window(1'b1, 1'b1, 60 / HSTD, "R7 override count");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule